// File: doc/BRIEF.md
# Codec Host Serial Port

This block is the synchronous, full-duplex serial link between a converter front end and a host signal processor. It divides the system clock down to a serial bit clock that it drives itself, moves 16-bit words in each direction with the most significant bit first, and generates its own output frame sync. The host marks each incoming word with a frame sync of its own. Incoming words are either register writes or samples for the DAC. Outgoing words carry ADC samples. The converters and filters are not part of the block. They appear as a sample strobe with a data bus on the ADC side and as a sample-period tick with a held output word on the DAC side.

A register write takes two framed words in a row. The first is an address word: bit 15 set, bits 14..3 zero, and the register number in bits 2..0. The second is the value. Every other word is a DAC sample, so the eight codes 0x8000 to 0x8007 cannot be used as samples. Chip select is active high. While it is low, the block's outputs are disabled and its inputs are ignored, and any word in flight in either direction is dropped. After reset the port sends nothing until the host sets the power-up bit, which is bit 3 of register 1.

Top module: `codec_sport`

## Requirements
- R1: A synchronous active-low reset clears all eight 16-bit registers to zero, clears the DAC output word, and holds port_oe, sdo and sdo_fs low.
- R2: sclk has a period of CLK_DIV system clocks and is high for the first CLK_DIV/2 of them. sdo and sdo_fs change only on a rising sclk edge. The block samples sdi and sdi_fs on falling sclk edges.
- R3: port_oe follows cs one clock later. While cs is low, frames on sdi/sdi_fs change no register and no DAC word, and ADC strobes produce no output frame.
- R4: If cs drops in the middle of a word, a partly received input word is discarded, and so is a partly sent output word. The next complete frame after cs returns is decoded normally.
- R5: An input frame is sdi_fs high for one bit slot, followed by 16 data bits, MSB first. An address word (bit 15 = 1, bits 14..3 = 0, register number in bits 2..0) followed by a second word writes that second word into the addressed register.
- R6: Any other input word is a DAC sample. dac_out takes the latest received sample on the next dac_tick. If no new sample arrived in the period, dac_out keeps its previous value across the tick.
- R7: No output frame is started unless bit 3 of register 1 (the power-up bit) is 1. ADC strobes that arrive while this bit is 0 are dropped.
- R8: An output frame is sdo_fs high for exactly one bit slot, followed by the 16 bits of the ADC sample, MSB first, one per slot.
- R9: If several ADC strobes arrive before the pending sample starts, only the newest one is sent. A sample that arrives while a frame is being sent goes out in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| sdi | input | 1 | Serial data from host |
| sdi_fs | input | 1 | Input frame sync from host |
| adc_stb | input | 1 | One-clock strobe: new ADC sample on adc_data |
| adc_data | input | 16 | ADC sample to send |
| dac_tick | input | 1 | One-clock DAC sample-period tick |
| sclk | output | 1 | Serial bit clock driven to host |
| sdo | output | 1 | Serial data to host |
| sdo_fs | output | 1 | Output frame sync |
| port_oe | output | 1 | Drive enable for sclk, sdo and sdo_fs (low means high impedance at the pad) |
| dac_out | output | 16 | Sample word held for the DAC |
| cfg_regs | output | 128 | Register file contents, register n in bits 16n+15..16n |

## Verification
The assertions check on every cycle that sdo and sdo_fs change only at a rising sclk edge unless chip select has just fallen, that no output frame starts without the power-up bit, that dac_out moves only on a tick, and that the registers stay frozen while chip select stays low. The bench scenarios are needed to show that the bits arrive in order and carry the right values. They also show that the address-then-value pairing lands in the right register, that the newest pending ADC sample wins, and that frames abandoned by chip select leave no trace.

// File: rtl/codec_sport_pkg.sv
// Shared widths, register-map constants and word decode for the codec serial port.
// Assumes a 16-bit word and a 3-bit register address.
package codec_sport_pkg;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned NUM_REGS = 1 << ADDR_W;
    localparam int unsigned CNT_W    = $clog2(WORD_W + 2);
    localparam int unsigned PWR_REG  = 1;
    localparam int unsigned PWR_BIT  = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Address word: top bit set, bits between top and address all zero.
    function automatic logic is_addr_word(input word_t w);
        return w[WORD_W-1] && (w[WORD_W-2:ADDR_W] == '0);
    endfunction
endpackage

// File: rtl/csp_bitclk.sv
// Bit clock generator: divides clk by CLK_DIV into sclk and gives one-cycle
// ticks ahead of the rising and falling sclk edges. CLK_DIV must be even and >= 4.
module csp_bitclk #(
    parameter int unsigned CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int unsigned PH_W = $clog2(CLK_DIV);
    localparam int unsigned HALF = CLK_DIV / 2;

    logic [PH_W-1:0] ph_q;

    // Phase counter wrapping every CLK_DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (ph_q == PH_W'(CLK_DIV - 1)) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign sclk      = (ph_q < PH_W'(HALF));
    assign rise_tick = (ph_q == PH_W'(CLK_DIV - 1));
    assign fall_tick = (ph_q == PH_W'(HALF - 1));
endmodule

// File: rtl/csp_rx.sv
// Input deserializer and word decoder. Samples sdi_fs/sdi on fall ticks,
// assembles 16-bit words and classifies them as address word, register value
// or DAC sample. Any deassertion of cs drops the word and a pending address.
module csp_rx
    import codec_sport_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs,
    input  logic  fall_tick,
    input  logic  sdi,
    input  logic  sdi_fs,
    output logic  wr_en,
    output addr_t wr_addr,
    output word_t wr_data,
    output logic  dac_en,
    output word_t dac_data
);
    logic [CNT_W-1:0] left_q;
    word_t            sh_q;
    logic             addr_pend_q;
    addr_t            addr_q;
    word_t            word_in;

    assign word_in = {sh_q[WORD_W-2:0], sdi};

    // Frame detection, bit shifting and word classification.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs) begin
            left_q      <= '0;
            sh_q        <= '0;
            addr_pend_q <= 1'b0;
            addr_q      <= '0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            dac_en      <= 1'b0;
            dac_data    <= '0;
        end else begin
            wr_en  <= 1'b0;
            dac_en <= 1'b0;
            if (fall_tick) begin
                if (left_q == '0) begin
                    if (sdi_fs) begin
                        left_q <= CNT_W'(WORD_W);
                    end
                end else begin
                    sh_q   <= word_in;
                    left_q <= left_q - 1'b1;
                    if (left_q == CNT_W'(1)) begin
                        if (addr_pend_q) begin
                            wr_en       <= 1'b1;
                            wr_addr     <= addr_q;
                            wr_data     <= word_in;
                            addr_pend_q <= 1'b0;
                        end else if (is_addr_word(word_in)) begin
                            addr_pend_q <= 1'b1;
                            addr_q      <= word_in[ADDR_W-1:0];
                        end else begin
                            dac_en   <= 1'b1;
                            dac_data <= word_in;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/csp_regs.sv
// Control register file: NUM_REGS words, written by the decoder, reset to zero.
// Exposes all words flat and the power-up bit.
module csp_regs
    import codec_sport_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  addr_t                      wr_addr,
    input  word_t                      wr_data,
    output logic [NUM_REGS*WORD_W-1:0] regs_flat,
    output logic                       pwr_on
);
    word_t regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // One register word, loaded when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (wr_en && (wr_addr == addr_t'(i))) begin
                regs_q[i] <= wr_data;
            end
        end
        assign regs_flat[i*WORD_W +: WORD_W] = regs_q[i];
    end

    assign pwr_on = regs_q[PWR_REG][PWR_BIT];
endmodule

// File: rtl/csp_tx.sv
// Output serializer: holds the newest ADC sample, and on rise ticks sends a
// one-slot frame sync followed by 16 bits MSB first. Needs pwr_on to start a
// frame; cs low drops the frame in flight and any pending sample.
module csp_tx
    import codec_sport_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs,
    input  logic  rise_tick,
    input  logic  pwr_on,
    input  logic  adc_stb,
    input  word_t adc_data,
    output logic  sdo,
    output logic  sdo_fs
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W + 1);

    logic             pend_q;
    word_t            buf_q;
    word_t            sh_q;
    logic [CNT_W-1:0] pos_q;
    logic             can_start;

    assign can_start = pend_q && pwr_on && ((pos_q == '0) || (pos_q == LAST_POS));

    // Sample holding, frame sequencing and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs) begin
            pend_q <= 1'b0;
            buf_q  <= '0;
            sh_q   <= '0;
            pos_q  <= '0;
            sdo    <= 1'b0;
            sdo_fs <= 1'b0;
        end else begin
            if (rise_tick) begin
                if (can_start) begin
                    sdo_fs <= 1'b1;
                    sdo    <= 1'b0;
                    sh_q   <= buf_q;
                    pos_q  <= CNT_W'(1);
                    pend_q <= 1'b0;
                end else if (pos_q == LAST_POS) begin
                    sdo_fs <= 1'b0;
                    sdo    <= 1'b0;
                    pos_q  <= '0;
                end else if (pos_q != '0) begin
                    sdo_fs <= 1'b0;
                    sdo    <= sh_q[WORD_W-1];
                    sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                    pos_q  <= pos_q + 1'b1;
                end
            end
            if (adc_stb && pwr_on) begin
                buf_q  <= adc_data;
                pend_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/codec_sport.sv
// Codec serial port top: bit clock, input decoder, register file, output
// serializer and the DAC sample hold. Assumes cs is synchronous to clk.
module codec_sport
    import codec_sport_pkg::*;
#(
    parameter int unsigned CLK_DIV = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs,
    input  logic                       sdi,
    input  logic                       sdi_fs,
    input  logic                       adc_stb,
    input  logic [WORD_W-1:0]          adc_data,
    input  logic                       dac_tick,
    output logic                       sclk,
    output logic                       sdo,
    output logic                       sdo_fs,
    output logic                       port_oe,
    output logic [WORD_W-1:0]          dac_out,
    output logic [NUM_REGS*WORD_W-1:0] cfg_regs
);
    logic  rise_tick, fall_tick;
    logic  wr_en, dac_en, pwr_on;
    addr_t wr_addr;
    word_t wr_data, dac_data, dac_next_q;

    csp_bitclk #(.CLK_DIV(CLK_DIV)) bitclk_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk),
        .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    csp_rx rx_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .fall_tick(fall_tick),
        .sdi(sdi), .sdi_fs(sdi_fs),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dac_en(dac_en), .dac_data(dac_data)
    );

    csp_regs regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .regs_flat(cfg_regs), .pwr_on(pwr_on)
    );

    csp_tx tx_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rise_tick(rise_tick),
        .pwr_on(pwr_on), .adc_stb(adc_stb), .adc_data(adc_data),
        .sdo(sdo), .sdo_fs(sdo_fs)
    );

    // Output drive enable registered from chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_oe <= 1'b0;
        end else begin
            port_oe <= cs;
        end
    end

    // DAC hold: latest received sample moves to dac_out on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_next_q <= '0;
            dac_out    <= '0;
        end else begin
            if (dac_en) begin
                dac_next_q <= dac_data;
            end
            if (dac_tick) begin
                dac_out <= dac_next_q;
            end
        end
    end
endmodule

// File: rtl/codec_sport_chk.sv
// Assertion checker for codec_sport, bound to every instance of the top.
module codec_sport_chk
    import codec_sport_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cs,
    input logic                       sclk,
    input logic                       sdo,
    input logic                       sdo_fs,
    input logic                       pwr_on,
    input logic                       dac_tick,
    input logic [WORD_W-1:0]          dac_out,
    input logic [NUM_REGS*WORD_W-1:0] cfg_regs
);
    // R7: an output frame starts only with the power-up bit set
    p_fs_needs_power_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_fs) |-> $past(pwr_on));

    // R2: frame sync moves only on a rising sclk edge unless cs has dropped
    p_fs_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo_fs) && $past(cs)) |-> $rose(sclk));

    // R8: data bits move only on a rising sclk edge unless cs has dropped
    p_sdo_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo) && $past(cs)) |-> $rose(sclk));

    // R6: the DAC word changes only on a tick
    p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_out) |-> $past(dac_tick));

    // R3: registers stay frozen while chip select stays low
    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !$past(cs) && !$past(cs, 2)) |-> $stable(cfg_regs));
endmodule

bind codec_sport codec_sport_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdo(sdo),
    .sdo_fs(sdo_fs),
    .pwr_on(cfg_regs[codec_sport_pkg::PWR_REG*codec_sport_pkg::WORD_W + codec_sport_pkg::PWR_BIT]),
    .dac_tick(dac_tick), .dac_out(dac_out), .cfg_regs(cfg_regs)
);

// File: tb/codec_sport_tb_top.sv
module codec_sport_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0, cs = 1'b1, sdi = 1'b0, sdi_fs = 1'b0;
    logic         adc_stb = 1'b0, dac_tick = 1'b0;
    logic [15:0]  adc_data = '0;
    logic         sclk, sdo, sdo_fs, port_oe;
    logic [15:0]  dac_out;
    logic [127:0] cfg_regs;

    int n_chk = 0, n_bad = 0;
    int cap_n = 0, fs_err = 0, mon_left = 0;
    logic [15:0] mon_sh = '0;
    logic [15:0] cap_w [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_sport #(.CLK_DIV(CLK_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sdi(sdi), .sdi_fs(sdi_fs),
        .adc_stb(adc_stb), .adc_data(adc_data), .dac_tick(dac_tick),
        .sclk(sclk), .sdo(sdo), .sdo_fs(sdo_fs), .port_oe(port_oe),
        .dac_out(dac_out), .cfg_regs(cfg_regs)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] reg_of(input int a);
        return cfg_regs[a*16 +: 16];
    endfunction

    // Output frame monitor: samples at falling sclk, away from data changes.
    always @(negedge sclk) begin
        #1;
        if (!rst_n || !port_oe) begin
            mon_left = 0;
        end else if (sdo_fs) begin
            if (mon_left != 0) fs_err++;
            mon_left = 16;
        end else if (mon_left > 0) begin
            mon_sh = {mon_sh[14:0], sdo};
            mon_left--;
            if (mon_left == 0 && cap_n < 256) begin
                cap_w[cap_n] = mon_sh;
                cap_n++;
            end
        end
    end

    task automatic send_bits(input logic [15:0] w, input int nbits);
        @(posedge sclk); #1 sdi_fs = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            @(posedge sclk); #1 sdi_fs = 1'b0; sdi = w[15-i];
        end
        @(posedge sclk); #1 sdi = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        send_bits(w, 16);
    endtask

    task automatic write_reg(input int a, input logic [15:0] v);
        send_word(16'h8000 | 16'(a));
        send_word(v);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic strobe(input logic [15:0] v);
        @(posedge clk); #1 adc_stb = 1'b1; adc_data = v;
        @(posedge clk); #1 adc_stb = 1'b0;
    endtask

    task automatic tick;
        @(posedge clk); #1 dac_tick = 1'b1;
        @(posedge clk); #1 dac_tick = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic wait_frames(input int n);
        for (int k = 0; k < 60 && cap_n < n; k++) @(negedge sclk);
        #2;
    endtask

    task automatic wait_slots(input int n);
        repeat (n) @(negedge sclk);
        #2;
    endtask

    task automatic wait_fs;
        for (int k = 0; k < 60 && !sdo_fs; k++) begin
            @(negedge sclk); #1;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] v, old, exp_w;
        int base, hi;

        // R1: reset state
        repeat (5) @(posedge clk);
        #1;
        check(port_oe == 1'b0, "R1", "port_oe in reset", port_oe, 0);
        check(cfg_regs == '0, "R1", "registers in reset", cfg_regs, 0);
        check(dac_out == '0 && sdo_fs == 1'b0 && sdo == 1'b0, "R1", "dac_out/sdo_fs/sdo", {dac_out, sdo_fs, sdo}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R3: enable follows cs
        check(port_oe == 1'b1, "R3", "port_oe with cs high", port_oe, 1);

        // R2: sclk period and duty
        @(posedge sclk); #1;
        hi = 1;
        for (int i = 1; i < CLK_DIV; i++) begin
            @(posedge clk); #1;
            if (sclk) hi++;
        end
        check(sclk == 1'b0, "R2", "sclk low at end of period", sclk, 0);
        @(posedge clk); #1;
        check(sclk == 1'b1, "R2", "sclk high after CLK_DIV clocks", sclk, 1);
        check(hi == CLK_DIV/2, "R2", "sclk high clocks", hi, CLK_DIV/2);

        // R7: powered down, strobes produce nothing
        strobe(16'h1234);
        wait_slots(40);
        check(cap_n == 0, "R7", "frames before power-up", cap_n, 0);

        // R5: write every register, power bit kept clear
        for (int a = 0; a < 8; a++) begin
            v = 16'((a * 16'h2B1D) + 16'h0F0F);
            if (a == 1) v = v & 16'hFFF7;
            write_reg(a, v);
            check(reg_of(a) == v, "R5", $sformatf("register %0d value", a), reg_of(a), v);
        end
        for (int a = 0; a < 8; a++) begin
            v = 16'((a * 16'h2B1D) + 16'h0F0F);
            if (a == 1) v = v & 16'hFFF7;
            check(reg_of(a) == v, "R5", $sformatf("register %0d kept", a), reg_of(a), v);
        end
        tick();
        check(dac_out == 16'h0000, "R5", "address/value words not samples", dac_out, 0);

        // R6: DAC samples, hold until tick, repeat without new sample
        foreach (cap_w[i]) if (i < 6) begin
            case (i)
                0: v = 16'h7FFF; 1: v = 16'h0001; 2: v = 16'h8008;
                3: v = 16'hFFFF; 4: v = 16'h5A5A; default: v = 16'h8010;
            endcase
            old = dac_out;
            send_word(v);
            repeat (3) @(posedge clk);
            #1;
            check(dac_out == old, "R6", "dac_out before tick", dac_out, old);
            tick();
            check(dac_out == v, "R6", "dac_out after tick", dac_out, v);
        end
        tick();
        check(dac_out == 16'h8010, "R6", "sample reused without new word", dac_out, 16'h8010);

        // R7: power up, then R8 walking ones and patterns
        write_reg(1, 16'h0008);
        check(cap_n == 0, "R7", "stale strobe not sent", cap_n, 0);
        for (int i = 0; i < 20; i++) begin
            exp_w = (i < 16) ? (16'h0001 << i) : 16'(16'hA5C3 ^ (i * 16'h1357));
            base = cap_n;
            strobe(exp_w);
            wait_frames(base + 1);
            check(cap_n == base + 1, "R8", "frame count", cap_n, base + 1);
            check(cap_w[base] == exp_w, "R8", "frame word", cap_w[base], exp_w);
        end
        check(fs_err == 0, "R8", "frame sync single slot", fs_err, 0);

        // R9: newest pending sample wins
        base = cap_n;
        strobe(16'hAAAA);
        wait_fs();
        strobe(16'hBBBB);
        wait_slots(3);
        strobe(16'hCCCC);
        wait_frames(base + 2);
        wait_slots(20);
        check(cap_n == base + 2, "R9", "frame count", cap_n, base + 2);
        check(cap_w[base] == 16'hAAAA, "R9", "first frame", cap_w[base], 16'hAAAA);
        check(cap_w[base+1] == 16'hCCCC, "R9", "second frame newest", cap_w[base+1], 16'hCCCC);

        // R4: output frame aborted by cs
        base = cap_n;
        strobe(16'hD00D);
        wait_fs();
        repeat (5) @(posedge sclk);
        #1 cs = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check(port_oe == 1'b0, "R3", "port_oe with cs low", port_oe, 0);
        repeat (3) @(posedge sclk);
        #1 cs = 1'b1;
        wait_slots(25);
        check(cap_n == base, "R4", "aborted frame not delivered", cap_n, base);
        strobe(16'hE00E);
        wait_frames(base + 1);
        check(cap_n == base + 1 && cap_w[base] == 16'hE00E, "R4", "frame after abort", cap_w[base], 16'hE00E);

        // R4: input word aborted by cs
        send_word(16'h8005);
        send_bits(16'hFFFF, 8);
        #1 cs = 1'b0;
        repeat (2) @(posedge sclk);
        #1 cs = 1'b1;
        write_reg(6, 16'h6C6C);
        check(reg_of(6) == 16'h6C6C, "R4", "write after aborted word", reg_of(6), 16'h6C6C);
        v = 16'((5 * 16'h2B1D) + 16'h0F0F);
        check(reg_of(5) == v, "R4", "aborted write left register", reg_of(5), v);

        // R3: inputs ignored with cs low
        #1 cs = 1'b0;
        old = dac_out;
        write_reg(2, 16'h0BAD);
        send_word(16'h1111);
        base = cap_n;
        strobe(16'h2222);
        repeat (3) @(posedge clk);
        tick();
        v = 16'((2 * 16'h2B1D) + 16'h0F0F);
        check(reg_of(2) == v, "R3", "register unchanged with cs low", reg_of(2), v);
        check(dac_out == old, "R3", "dac unchanged with cs low", dac_out, old);
        #1 cs = 1'b1;
        wait_slots(30);
        check(cap_n == base, "R3", "no frame from strobe with cs low", cap_n, base);

        // R7: power down again stops frames
        write_reg(1, 16'h0000);
        base = cap_n;
        strobe(16'h3333);
        wait_slots(30);
        check(cap_n == base, "R7", "no frame after power-down", cap_n, base);

        // R1: reset mid-operation
        write_reg(1, 16'h0008);
        write_reg(4, 16'h4444);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(cfg_regs == '0 && port_oe == 1'b0, "R1", "registers and enable after reset", cfg_regs, 0);
        rst_n = 1'b1;
        base = cap_n;
        strobe(16'h5555);
        wait_slots(30);
        check(cap_n == base, "R1", "powered down after reset", cap_n, base);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule